// File: doc/BRIEF.md
# Switch-on-stall SIMD thread issue controller

This block decides, every clock, which hardware thread context of a single SIMD core issues its next vector instruction to the 32-lane ALU array. It holds a fixed number of contexts on chip. A running context keeps issuing until it issues a texture fetch. That fetch stalls it for a fixed latency, and in the very next cycle issue moves to another context that is able to run. Each context carries its own program counter and its own position within its run of arithmetic instructions. The block also reports the context's state and the base of its slice of the shared vector register file.

The instruction stream is modelled by position. A thread issues a fixed number of arithmetic instructions, then one texture fetch, and the pattern repeats. Utilisation is shown by the issue strobe and by a saturating count of cycles in which nothing issued. With four contexts, runs of 20 arithmetic instructions and a 50-cycle texture latency, that count stays at zero.

Top module: `stall_switch_sched`

## Requirements
- R1: After reset, context 0 is executing and issues program counter 0 in the first cycle, all other contexts are ready, and the idle count is 0.
- R2: At most one instruction issues per cycle. `issue_valid` is high exactly when one context is executing, and never more than one context executes.
- R3: Each context's issued program counters start at 0 and rise by one per issue. An issue is flagged texture (`issue_is_tex`=1) when pc mod (ALU_RUN+1) equals ALU_RUN, and arithmetic otherwise.
- R4: A context that issues a texture fetch in cycle c is stalled from cycle c+1 through c+TEX_LAT-1. From cycle c+TEX_LAT it is eligible to issue again.
- R5: An executing context that issues an arithmetic instruction also issues in the next cycle. No context is preempted.
- R6: After a texture issue by context t in cycle c, cycle c+1 issues from the first eligible context in the order t+1, t+2, ... (wrapping), excluding t.
- R7: In a cycle with no eligible context, `issue_valid` is low and the idle count grows by one, visible in the next cycle. While idle, the first context to become eligible issues in its first eligible cycle. The search starts after the last context that issued.
- R8: `issue_rf_base` equals issue_tid × REGS_PER_CTX. With defaults, context t owns physical registers 4t to 4t+3.
- R9: `ctx_state` holds 2 bits per context, with context k at bits [2k+1:2k]. The codes are 0 ready, 1 executing and 2 stalled.
- R10: With 4 contexts, ALU_RUN=20 and TEX_LAT=50, context 0 issues a texture fetch at cycle 20 and resumes at cycle 84 with pc 21, and the idle count stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_tid | output | $clog2(NUM_CTX) | Issuing context |
| issue_pc | output | PC_W | Program counter of the issued instruction |
| issue_is_tex | output | 1 | Issued instruction is a texture fetch |
| issue_rf_base | output | $clog2(NUM_CTX*REGS_PER_CTX) | First physical vector register of the issuing context |
| ctx_state | output | 2*NUM_CTX | Per-context state codes |
| idle_count | output | IDLE_W | Saturating count of cycles without issue |

## Verification
The assertions assume that TEX_LAT is at least 2 and ALU_RUN is at least 0. They also assume that the idle count never reaches saturation in a check window, and that no program counter wraps. The bench runs three small configurations for a few hundred cycles each. The first uses the defaults. The second has three contexts with short runs and a long latency, so idle gaps appear. The third fetches a texture on every instruction with the shortest latency. Counts and program counters therefore stay far from their limits, and the parameter rule holds.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    CTX_READY = 2'd0,
    CTX_EXEC  = 2'd1,
    CTX_STALL = 2'd2
  } ctx_state_e;
endpackage

// File: rtl/ctx_slot.sv
module ctx_slot
  import sched_pkg::*;
#(
  parameter int ALU_RUN    = 20,
  parameter int TEX_LAT    = 50,
  parameter int PC_W       = 16,
  parameter int RUN_W      = 5,
  parameter int LAT_W      = 6,
  parameter bit START_EXEC = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_en,
  input  logic             pick,
  output ctx_state_e       state_o,
  output logic [PC_W-1:0]  pc_o,
  output logic             tex_o,
  output logic             elig_o
);
  ctx_state_e             st_q, st_d;
  logic [PC_W-1:0]        pc_q, pc_d;
  logic [RUN_W-1:0]       run_q, run_d;
  logic [LAT_W-1:0]       cnt_q, cnt_d;
  logic                   lat_done;

  assign lat_done = (cnt_q == LAT_W'(1));
  assign tex_o    = (run_q == RUN_W'(ALU_RUN));
  assign elig_o   = (st_q == CTX_READY) || ((st_q == CTX_STALL) && lat_done);
  assign state_o  = st_q;
  assign pc_o     = pc_q;

  always_comb begin
    st_d  = st_q;
    pc_d  = pc_q;
    run_d = run_q;
    cnt_d = cnt_q;
    if (issue_en) begin
      pc_d  = pc_q + PC_W'(1);
      run_d = tex_o ? '0 : run_q + RUN_W'(1);
    end
    unique case (st_q)
      CTX_EXEC: if (issue_en && tex_o) begin
        st_d  = CTX_STALL;
        cnt_d = LAT_W'(TEX_LAT - 1);
      end
      CTX_STALL: begin
        if (lat_done) st_d = pick ? CTX_EXEC : CTX_READY;
        else          cnt_d = cnt_q - LAT_W'(1);
      end
      CTX_READY: if (pick) st_d = CTX_EXEC;
      default: st_d = CTX_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= START_EXEC ? CTX_EXEC : CTX_READY;
      pc_q  <= '0;
      run_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      pc_q  <= pc_d;
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  // R2: only the executing context may be told to issue
  a_r2_issue_only_exec: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |-> (st_q == CTX_EXEC));
  // R4: a stalled context whose countdown is not finished stays stalled
  a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CTX_STALL && !lat_done) |=> (st_q == CTX_STALL));
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int NUM = 4,
  parameter int TW  = 2
) (
  input  logic [NUM-1:0] elig,
  input  logic [TW-1:0]  start,
  output logic           found,
  output logic [TW-1:0]  sel
);
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int k = 0; k < NUM; k++) begin
      int c;
      c = int'(start) + k;
      if (c >= NUM) c = c - NUM;
      if (!found && elig[c]) begin
        found = 1'b1;
        sel   = TW'(c);
      end
    end
  end
endmodule

// File: rtl/stall_switch_sched.sv
module stall_switch_sched
  import sched_pkg::*;
#(
  parameter int NUM_CTX      = 4,
  parameter int REGS_PER_CTX = 4,
  parameter int ALU_RUN      = 20,
  parameter int TEX_LAT      = 50,
  parameter int PC_W         = 16,
  parameter int IDLE_W       = 16,
  localparam int TW          = $clog2(NUM_CTX),
  localparam int RFW         = $clog2(NUM_CTX * REGS_PER_CTX)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic                 issue_valid,
  output logic [TW-1:0]        issue_tid,
  output logic [PC_W-1:0]      issue_pc,
  output logic                 issue_is_tex,
  output logic [RFW-1:0]       issue_rf_base,
  output logic [2*NUM_CTX-1:0] ctx_state,
  output logic [IDLE_W-1:0]    idle_count
);
  localparam int RUN_W = $clog2(ALU_RUN + 2);
  localparam int LAT_W = $clog2(TEX_LAT + 1);

  logic [TW-1:0]     cur_q, cur_d, last_q, start;
  logic              vld_q, vld_d;
  logic [IDLE_W-1:0] idle_q;
  logic              idle_en;
  logic [NUM_CTX-1:0] elig, tex_v, pick_v, issue_v;
  logic [PC_W-1:0]   pc_arr [NUM_CTX];
  ctx_state_e        st_arr [NUM_CTX];
  logic              found, need_pick;
  logic [TW-1:0]     sel;

  for (genvar k = 0; k < NUM_CTX; k++) begin : g_ctx
    assign issue_v[k] = vld_q && (cur_q == TW'(k));
    assign pick_v[k]  = need_pick && found && (sel == TW'(k));
    ctx_slot #(
      .ALU_RUN(ALU_RUN), .TEX_LAT(TEX_LAT), .PC_W(PC_W),
      .RUN_W(RUN_W), .LAT_W(LAT_W), .START_EXEC(k == 0)
    ) u_slot (
      .clk(clk), .rst_n(rst_n), .issue_en(issue_v[k]), .pick(pick_v[k]),
      .state_o(st_arr[k]), .pc_o(pc_arr[k]), .tex_o(tex_v[k]), .elig_o(elig[k])
    );
    assign ctx_state[2*k +: 2] = st_arr[k];
  end

  // Search begins after the running context, or after the last issuer when idle
  always_comb begin
    logic [TW-1:0] base;
    base  = vld_q ? cur_q : last_q;
    start = (base == TW'(NUM_CTX - 1)) ? '0 : base + TW'(1);
  end

  rr_pick #(.NUM(NUM_CTX), .TW(TW)) u_pick (
    .elig(elig), .start(start), .found(found), .sel(sel)
  );

  assign issue_valid   = vld_q;
  assign issue_tid     = cur_q;
  assign issue_pc      = pc_arr[cur_q];
  assign issue_is_tex  = vld_q && tex_v[cur_q];
  assign issue_rf_base = RFW'(int'(cur_q) * REGS_PER_CTX);
  assign idle_count    = idle_q;
  assign need_pick     = !vld_q || tex_v[cur_q];
  assign idle_en       = !vld_q && (idle_q != '1);

  always_comb begin
    cur_d = cur_q;
    vld_d = vld_q;
    if (need_pick) begin
      vld_d = found;
      if (found) cur_d = sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      vld_q  <= 1'b1;
      last_q <= TW'(NUM_CTX - 1);
      idle_q <= '0;
    end else begin
      cur_q <= cur_d;
      vld_q <= vld_d;
      if (vld_q)   last_q <= cur_q;
      if (idle_en) idle_q <= idle_q + IDLE_W'(1);
    end
  end

  // R2: issue strobe agrees with the per-context states
  a_r2_one_exec: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(issue_v) <= 1 && (issue_valid == (st_arr[cur_q] == CTX_EXEC)));
  // R4: the context that fetched a texture is stalled next cycle
  a_r4_stall_after_tex: assert property (@(posedge clk) disable iff (!rst_n)
    issue_is_tex |=> (st_arr[$past(issue_tid)] == CTX_STALL));
  // R5: arithmetic issue keeps the same context running with the next pc
  a_r5_keep_running: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_is_tex) |=>
      (issue_valid && issue_tid == $past(issue_tid) && issue_pc == $past(issue_pc) + PC_W'(1)));
  // R6: a texture issue hands the core to a different context
  a_r6_switch_away: assert property (@(posedge clk) disable iff (!rst_n)
    issue_is_tex |=> (!issue_valid || issue_tid != $past(issue_tid)));
  // R7: an idle cycle raises the idle count by one
  a_r7_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_valid && idle_count != '1) |=> (idle_count == $past(idle_count) + IDLE_W'(1)));
endmodule

// File: tb/stall_switch_sched_tb_top.sv
`timescale 1ns/1ps
module sched_ref_chk #(
  parameter int N     = 4,
  parameter int RUN   = 20,
  parameter int LAT   = 50,
  parameter int CYC   = 400,
  parameter bit EXAMP = 1'b0
) (
  input  logic clk,
  output int   n_chk,
  output int   n_bad,
  output logic done
);
  localparam int TW  = $clog2(N);
  localparam int RFW = $clog2(N * 4);
  logic             rst_n;
  logic             v, tex;
  logic [TW-1:0]    tid;
  logic [15:0]      pc, idle;
  logic [RFW-1:0]   rfb;
  logic [2*N-1:0]   st;

  stall_switch_sched #(.NUM_CTX(N), .REGS_PER_CTX(4), .ALU_RUN(RUN), .TEX_LAT(LAT),
                       .PC_W(16), .IDLE_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .issue_valid(v), .issue_tid(tid), .issue_pc(pc),
    .issue_is_tex(tex), .issue_rf_base(rfb), .ctx_state(st), .idle_count(idle));

  task automatic chk(input bit ok, input string req, input int cyc, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cfg N=%0d RUN=%0d LAT=%0d cycle %0d: got %0d expected %0d",
               req, N, RUN, LAT, cyc, act, exp);
    end
  endtask

  initial begin
    int rdy_t [N];
    int pcs [N];
    int run, last, nidle;
    n_chk = 0; n_bad = 0; done = 1'b0;
    run = 0; last = N - 1; nidle = 0;
    for (int k = 0; k < N; k++) begin rdy_t[k] = 0; pcs[k] = 0; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: state right after reset
    chk(v == 1'b1 && tid == 0 && pc == 0, "R1", 0, int'(pc), 0);
    chk(st == {{(N-1){2'd0}}, 2'd1}, "R1", 0, int'(st), 1);
    chk(idle == 0, "R1", 0, int'(idle), 0);
    for (int n = 0; n < CYC; n++) begin
      bit ev, et;
      if (run < 0) begin
        for (int k = 1; k <= N; k++) begin
          int c;
          c = (last + k) % N;
          if (run < 0 && rdy_t[c] <= n) run = c;
        end
      end
      ev = (run >= 0);
      chk(v == ev, "R2/R7 issue_valid", n, int'(v), int'(ev));
      chk(int'(idle) == nidle, "R7 idle_count", n, int'(idle), nidle);
      for (int k = 0; k < N; k++) begin
        int es;
        es = (k == run) ? 1 : (rdy_t[k] > n) ? 2 : 0;
        chk(int'(st[2*k +: 2]) == es, "R9/R4 ctx_state", n, int'(st[2*k +: 2]), es);
      end
      if (ev) begin
        et = (pcs[run] % (RUN + 1)) == RUN;
        chk(int'(tid) == run, "R6/R5 issue_tid", n, int'(tid), run);
        chk(int'(pc) == pcs[run], "R3 issue_pc", n, int'(pc), pcs[run]);
        chk(tex == et, "R3 issue_is_tex", n, int'(tex), int'(et));
        chk(int'(rfb) == run * 4, "R8 issue_rf_base", n, int'(rfb), run * 4);
        if (EXAMP && n == 20) chk(tid == 0 && tex, "R10 texture at 20", n, int'(tid), 0);
        if (EXAMP && n == 84) chk(tid == 0 && pc == 21, "R10 resume at 84", n, int'(pc), 21);
        pcs[run]++;
        last = run;
        if (et) begin
          int r;
          r = run;
          rdy_t[r] = n + LAT;
          run = -1;
          for (int k = 1; k < N; k++) begin
            int c;
            c = (r + k) % N;
            if (run < 0 && rdy_t[c] <= n + 1) run = c;
          end
        end
      end else begin
        nidle++;
      end
      @(negedge clk);
      #1;
    end
    if (EXAMP) chk(idle == 0, "R10 no idle cycles", CYC, int'(idle), 0);
    else       chk(int'(idle) == nidle, "R7 final idle_count", CYC, int'(idle), nidle);
    done = 1'b1;
  end
endmodule

module stall_switch_sched_tb_top;
  logic clk;
  int   c0, b0, c1, b1, c2, b2;
  logic d0, d1, d2;
  int   total, bad;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  sched_ref_chk #(.N(4), .RUN(20), .LAT(50), .CYC(500), .EXAMP(1'b1))
    u_dflt (.clk(clk), .n_chk(c0), .n_bad(b0), .done(d0));
  sched_ref_chk #(.N(3), .RUN(3), .LAT(20), .CYC(300), .EXAMP(1'b0))
    u_gaps (.clk(clk), .n_chk(c1), .n_bad(b1), .done(d1));
  sched_ref_chk #(.N(4), .RUN(0), .LAT(2), .CYC(200), .EXAMP(1'b0))
    u_tight (.clk(clk), .n_chk(c2), .n_bad(b2), .done(d2));

  initial begin
    int cyc;
    cyc = 0;
    while (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1) && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    #2;
    total = c0 + c1 + c2;
    bad   = b0 + b1 + b2;
    if (cyc >= 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
    end
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end
endmodule